// File: doc/BRIEF.md
# Sticky Lock and Erase Status Register Block

This block holds three banks of one-way lock bits and a pair of hardware-set erase status flags, all reached through a small single-beat register port. Software can set a lock bit by writing 1 to it. Software cannot clear it: only a system or power-on reset does that. The safety bank's lock bits gate four fault sources (CPU lockup, memory parity error, supply monitor event, ECC double error) onto one registered break output for a timer. The supply-monitor lock also drives a read-only request to the supply-monitor configuration.

The two erase flags are set by one-cycle completion pulses from an erase engine. Software clears each one by writing 1 to its bit. If a set pulse and a clear arrive in the same cycle, the set wins. The full-memory-erase flag lives in the power-on reset domain, so a system reset leaves it alone. The cache/accelerator-RAM flag follows system reset like every other bit.

The port has a two-state handshake FSM. In `ST_IDLE`, a request is accepted: a write updates the target register at that edge, and a read captures its data. The FSM then moves to `ST_ACK` (transition *accept*). There it drives `bus_ack` for one cycle, together with the read data, and ignores `bus_req`. It then returns to `ST_IDLE` (transition *complete*).

Top module: `sticky_lock_regs`

## Requirements
- R1: After power-on reset, every lock output, `brk_out`, `supmon_ro`, `bus_ack` and both erase flags read 0.
- R2: A write to word 0 (nonsecure locks, bits [1:0]) or word 1 (secure locks, bits [2:0]) ORs the written bits into the bank. Writing 0 leaves a set bit unchanged.
- R3: Word 2 is the safety bank, with bit 0 = CPU lockup, bit 1 = parity error, bit 2 = supply monitor and bit 3 = ECC double error. It is set-only like R2, and its value appears on `safety_lock`.
- R4: `supmon_ro` is 1 exactly while safety bit 2 is set.
- R5: One cycle after any cycle where `fault_in[i] & safety_lock[i]` is true for some i, `brk_out` is 1. Otherwise it is 0 one cycle later.
- R6: Word 3 holds the erase flags, full erase at bit 0 and cache/accelerator RAM erase at bit 16. A pulse on `full_erase_done` / `cache_erase_done` sets its flag. Writing 1 to the bit clears it, and writing 0 has no effect.
- R7: A set pulse in the same cycle as a write-1 clear to the same flag leaves the flag set.
- R8: A system reset clears all locks and the bit-16 flag but keeps the bit-0 flag. Only `por_n` clears bit 0.
- R9: All bits not named in R2, R3 and R6 read 0 and ignore writes.
- R10: A request is accepted only in `ST_IDLE`. `bus_ack` is high for exactly the cycle after acceptance, with `bus_rdata` holding the pre-write value of the addressed word. A request seen during `ST_ACK` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | Access completion |
| fault_in | input | 4 | Fault sources (lockup, parity, supply, ECC) |
| full_erase_done | input | 1 | Set pulse for the full-erase flag |
| cache_erase_done | input | 1 | Set pulse for the cache/accelerator erase flag |
| ns_lock | output | 2 | Nonsecure lock bits |
| s_lock | output | 3 | Secure lock bits |
| safety_lock | output | 4 | Fault routing enables |
| supmon_ro | output | 1 | Supply-monitor configuration read-only request |
| brk_out | output | 1 | Registered break output |

## Verification
The hardest state to reach from the ports is the same-cycle collision of an erase-engine pulse with the software clear. The stimulus gets there by raising the done pulse on the very cycle the write-1 request is accepted in `ST_IDLE`.

A second awkward state is a full-erase flag that is still set after a system reset while every other bit has been cleared. The bench sets both flags, pulses only `sys_rst_n`, and reads word 3 back before pulsing `por_n`.

A behavioural model, with its own reset domains, checks every output on every clock across these sequences.

// File: rtl/sticky_pkg.sv
package sticky_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 2;
    localparam int NS_LOCK_W  = 2;
    localparam int S_LOCK_W   = 3;
    localparam int FLT_N      = 4;
    localparam int SUPMON_IDX = 2;
    localparam int FULL_BIT   = 0;
    localparam int CACHE_BIT  = 16;

    localparam logic [ADDR_W-1:0] WA_NS    = 2'd0;
    localparam logic [ADDR_W-1:0] WA_S     = 2'd1;
    localparam logic [ADDR_W-1:0] WA_SAFE  = 2'd2;
    localparam logic [ADDR_W-1:0] WA_ERASE = 2'd3;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } bus_st_e;
endpackage

// File: rtl/lock_bank.sv
module lock_bank #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         sys_rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge por_n or negedge sys_rst_n) begin
        if (!por_n || !sys_rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= q | wdata;
        end
    end

    // Once set, a bit stays set until reset.
    assert_lock_monotonic_R2: assert property (@(posedge clk)
        disable iff (!por_n || !sys_rst_n)
        1'b1 |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/erase_flag.sv
module erase_flag #(
    parameter bit KEEP_ON_SYS = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst_n,
    input  logic set_pulse,
    input  logic clr_w1,
    output logic q
);
    logic q_nxt;

    always_comb begin
        if (set_pulse)   q_nxt = 1'b1;
        else if (clr_w1) q_nxt = 1'b0;
        else             q_nxt = q;
    end

    generate
        if (KEEP_ON_SYS) begin : g_por_domain
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) q <= 1'b0;
                else        q <= q_nxt;
            end

            // R8: a set flag with no clear survives anything but power-on reset.
            assert_keep_on_sys_R8: assert property (@(posedge clk)
                disable iff (!por_n)
                (q && !clr_w1) |=> q);
        end else begin : g_sys_domain
            always_ff @(posedge clk or negedge por_n or negedge sys_rst_n) begin
                if (!por_n || !sys_rst_n) q <= 1'b0;
                else                      q <= q_nxt;
            end
        end
    endgenerate

    assert_set_wins_R7: assert property (@(posedge clk)
        disable iff (!por_n || !sys_rst_n)
        set_pulse |=> q);
endmodule

// File: rtl/fault_break.sv
module fault_break #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         sys_rst_n,
    input  logic [N-1:0] fault,
    input  logic [N-1:0] route_en,
    output logic         brk
);
    logic [N-1:0] gated;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_gate
            assign gated[i] = fault[i] & route_en[i];
        end
    endgenerate

    always_ff @(posedge clk or negedge por_n or negedge sys_rst_n) begin
        if (!por_n || !sys_rst_n) brk <= 1'b0;
        else                      brk <= |gated;
    end

    assert_brk_raise_R5: assert property (@(posedge clk)
        disable iff (!por_n || !sys_rst_n)
        (|(fault & route_en)) |=> brk);

    assert_brk_quiet_R5: assert property (@(posedge clk)
        disable iff (!por_n || !sys_rst_n)
        !(|(fault & route_en)) |=> !brk);
endmodule

// File: rtl/sticky_lock_regs.sv
module sticky_lock_regs
    import sticky_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    input  logic [FLT_N-1:0]  fault_in,
    input  logic              full_erase_done,
    input  logic              cache_erase_done,
    output logic [NS_LOCK_W-1:0] ns_lock,
    output logic [S_LOCK_W-1:0]  s_lock,
    output logic [FLT_N-1:0]     safety_lock,
    output logic              supmon_ro,
    output logic              brk_out
);
    bus_st_e st_q, st_d;
    logic    accept;
    logic    wr_ns, wr_s, wr_safe, wr_erase;
    logic    full_q, cache_q;
    logic [DATA_W-1:0] rd_mux;

    // State register
    always_ff @(posedge clk or negedge por_n or negedge sys_rst_n) begin
        if (!por_n || !sys_rst_n) st_q <= ST_IDLE;
        else                      st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (bus_req) st_d = ST_ACK;
            ST_ACK:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Outputs of the FSM
    always_comb begin
        accept  = 1'b0;
        bus_ack = 1'b0;
        unique case (st_q)
            ST_IDLE: accept  = bus_req;
            ST_ACK:  bus_ack = 1'b1;
            default: ;
        endcase
    end

    assign wr_ns    = accept && bus_we && (bus_addr == WA_NS);
    assign wr_s     = accept && bus_we && (bus_addr == WA_S);
    assign wr_safe  = accept && bus_we && (bus_addr == WA_SAFE);
    assign wr_erase = accept && bus_we && (bus_addr == WA_ERASE);

    lock_bank #(.W(NS_LOCK_W)) u_ns_bank (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .wr_en(wr_ns), .wdata(bus_wdata[NS_LOCK_W-1:0]), .q(ns_lock)
    );

    lock_bank #(.W(S_LOCK_W)) u_s_bank (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .wr_en(wr_s), .wdata(bus_wdata[S_LOCK_W-1:0]), .q(s_lock)
    );

    lock_bank #(.W(FLT_N)) u_safe_bank (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .wr_en(wr_safe), .wdata(bus_wdata[FLT_N-1:0]), .q(safety_lock)
    );

    erase_flag #(.KEEP_ON_SYS(1'b1)) u_full_flag (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .set_pulse(full_erase_done),
        .clr_w1(wr_erase && bus_wdata[FULL_BIT]),
        .q(full_q)
    );

    erase_flag #(.KEEP_ON_SYS(1'b0)) u_cache_flag (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .set_pulse(cache_erase_done),
        .clr_w1(wr_erase && bus_wdata[CACHE_BIT]),
        .q(cache_q)
    );

    fault_break #(.N(FLT_N)) u_break (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .fault(fault_in), .route_en(safety_lock), .brk(brk_out)
    );

    assign supmon_ro = safety_lock[SUPMON_IDX];

    // Read mux: reserved bits are zero
    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            WA_NS:    rd_mux[NS_LOCK_W-1:0] = ns_lock;
            WA_S:     rd_mux[S_LOCK_W-1:0]  = s_lock;
            WA_SAFE:  rd_mux[FLT_N-1:0]     = safety_lock;
            WA_ERASE: begin
                rd_mux[FULL_BIT]  = full_q;
                rd_mux[CACHE_BIT] = cache_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge por_n or negedge sys_rst_n) begin
        if (!por_n || !sys_rst_n) bus_rdata <= '0;
        else if (accept)          bus_rdata <= rd_mux;
    end

    assert_ack_single_R10: assert property (@(posedge clk)
        disable iff (!por_n || !sys_rst_n)
        bus_ack |=> !bus_ack);

    assert_ack_follows_req_R10: assert property (@(posedge clk)
        disable iff (!por_n || !sys_rst_n)
        (!bus_ack && bus_req) |=> bus_ack);

    assert_supmon_sticky_R4: assert property (@(posedge clk)
        disable iff (!por_n || !sys_rst_n)
        supmon_ro |=> supmon_ro);
endmodule

// File: tb/sticky_lock_regs_tb_top.sv
module sticky_lock_regs_tb_top;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic [3:0]  fault_in = '0;
    logic        full_erase_done = 1'b0;
    logic        cache_erase_done = 1'b0;
    logic [1:0]  ns_lock;
    logic [2:0]  s_lock;
    logic [3:0]  safety_lock;
    logic        supmon_ro;
    logic        brk_out;

    int tests = 0;
    int fails = 0;
    logic [31:0] rd;

    always #2 clk = ~clk;

    sticky_lock_regs dut_i (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .fault_in(fault_in), .full_erase_done(full_erase_done),
        .cache_erase_done(cache_erase_done), .ns_lock(ns_lock),
        .s_lock(s_lock), .safety_lock(safety_lock), .supmon_ro(supmon_ro),
        .brk_out(brk_out)
    );

    // Behavioural reference model
    int          m_ns, m_s, m_safe, m_full, m_cache, m_brk, m_busy;
    logic [31:0] m_rdata;

    function automatic logic [31:0] m_read(input int a);
        logic [31:0] v = '0;
        case (a)
            0: v = m_ns;
            1: v = m_s;
            2: v = m_safe;
            default: v = (m_cache << 16) | m_full;
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        if (!por_n) begin
            m_ns = 0; m_s = 0; m_safe = 0; m_full = 0; m_cache = 0;
            m_brk = 0; m_busy = 0; m_rdata = '0;
        end else if (!sys_rst_n) begin
            m_ns = 0; m_s = 0; m_safe = 0; m_cache = 0;
            m_brk = 0; m_busy = 0; m_rdata = '0;
            if (full_erase_done) m_full = 1;
        end else begin
            bit acc;
            int clr_full, clr_cache;
            m_brk = ((fault_in & m_safe[3:0]) != 0) ? 1 : 0;
            acc = bus_req && (m_busy == 0);
            clr_full = 0; clr_cache = 0;
            if (acc) begin
                m_rdata = m_read(bus_addr);
                if (bus_we) begin
                    case (bus_addr)
                        0: m_ns   = m_ns   | bus_wdata[1:0];
                        1: m_s    = m_s    | bus_wdata[2:0];
                        2: m_safe = m_safe | bus_wdata[3:0];
                        default: begin
                            clr_full  = bus_wdata[0];
                            clr_cache = bus_wdata[16];
                        end
                    endcase
                end
            end
            if (full_erase_done)  m_full = 1;  else if (clr_full != 0)  m_full = 0;
            if (cache_erase_done) m_cache = 1; else if (clr_cache != 0) m_cache = 0;
            m_busy = acc ? 1 : 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (por_n && sys_rst_n) begin
            chk(ns_lock == m_ns[1:0], "R2 ns_lock", 32'(ns_lock), 32'(m_ns));
            chk(s_lock == m_s[2:0], "R2 s_lock", 32'(s_lock), 32'(m_s));
            chk(safety_lock == m_safe[3:0], "R3 safety_lock", 32'(safety_lock), 32'(m_safe));
            chk(supmon_ro == m_safe[2], "R4 supmon_ro", 32'(supmon_ro), 32'(m_safe[2]));
            chk(brk_out == m_brk[0], "R5 brk_out", 32'(brk_out), 32'(m_brk));
            chk(bus_ack == m_busy[0], "R10 bus_ack", 32'(bus_ack), 32'(m_busy));
            if (m_busy != 0)
                chk(bus_rdata == m_rdata, "R9 bus_rdata", bus_rdata, m_rdata);
        end
    end

    task automatic access(input bit we, input logic [1:0] a, input logic [31:0] d,
                          output logic [31:0] r);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        r = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        logic [31:0] r;
        access(1'b1, a, d, r);
    endtask

    task automatic rdw(input logic [1:0] a, output logic [31:0] r);
        access(1'b0, a, 32'h0, r);
    endtask

    task automatic pulse_full();
        @(negedge clk); full_erase_done = 1'b1;
        @(negedge clk); full_erase_done = 1'b0;
    endtask

    task automatic pulse_cache();
        @(negedge clk); cache_erase_done = 1'b1;
        @(negedge clk); cache_erase_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1; sys_rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({ns_lock, s_lock, safety_lock, supmon_ro, brk_out, bus_ack} == '0,
            "R1 outputs after reset", 32'({ns_lock, s_lock, safety_lock}), 32'h0);
        rdw(2'd3, rd);
        chk(rd == 32'h0, "R1 erase flags after reset", rd, 32'h0);

        // R2: set-only lock banks
        wr(2'd0, 32'h2);
        wr(2'd0, 32'h0);
        rdw(2'd0, rd); chk(rd == 32'h2, "R2 write 0 keeps ns bit", rd, 32'h2);
        wr(2'd0, 32'hFFFF_FFFF);
        rdw(2'd0, rd); chk(rd == 32'h3, "R9 ns reserved read zero", rd, 32'h3);
        wr(2'd1, 32'h5);
        wr(2'd1, 32'h0);
        rdw(2'd1, rd); chk(rd == 32'h5, "R2 secure bank", rd, 32'h5);

        // R3/R4/R5: routing
        fault_in = 4'b0101;
        repeat (3) @(negedge clk);
        chk(brk_out == 1'b0, "R5 no lock no break", 32'(brk_out), 32'h0);
        wr(2'd2, 32'h4);
        chk(supmon_ro == 1'b1, "R4 supmon read-only", 32'(supmon_ro), 32'h1);
        @(negedge clk);
        chk(brk_out == 1'b1, "R5 supply fault routed", 32'(brk_out), 32'h1);
        fault_in = 4'b1001;
        repeat (2) @(negedge clk);
        chk(brk_out == 1'b0, "R5 unlocked faults blocked", 32'(brk_out), 32'h0);
        wr(2'd2, 32'hFFFF_FFF9);
        rdw(2'd2, rd); chk(rd == 32'hD, "R3 safety bank bits", rd, 32'hD);
        fault_in = 4'b0000;
        repeat (2) @(negedge clk);

        // R6: erase flags
        pulse_full(); pulse_cache();
        rdw(2'd3, rd); chk(rd == 32'h0001_0001, "R6 both flags set", rd, 32'h0001_0001);
        wr(2'd3, 32'h0);
        rdw(2'd3, rd); chk(rd == 32'h0001_0001, "R6 write 0 no effect", rd, 32'h0001_0001);
        wr(2'd3, 32'h0001_0000);
        rdw(2'd3, rd); chk(rd == 32'h1, "R6 clear cache flag", rd, 32'h1);

        // R7: set pulse collides with clear
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 2'd3; bus_wdata = 32'h0001_0001;
        full_erase_done = 1'b1; cache_erase_done = 1'b1;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; full_erase_done = 1'b0; cache_erase_done = 1'b0;
        rdw(2'd3, rd); chk(rd == 32'h0001_0001, "R7 set wins over clear", rd, 32'h0001_0001);

        // R10: request held through the ack cycle is ignored there
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 2'd3; bus_wdata = 32'h1;
        @(negedge clk);
        chk(bus_ack == 1'b1, "R10 ack after accept", 32'(bus_ack), 32'h1);
        bus_wdata = 32'h0001_0000;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        rdw(2'd3, rd); chk(rd == 32'h0001_0000, "R10 request in ack ignored", rd, 32'h0001_0000);

        // R8: system reset keeps the full-erase flag
        pulse_full();
        @(negedge clk); sys_rst_n = 1'b0;
        repeat (2) @(negedge clk); sys_rst_n = 1'b1;
        @(negedge clk);
        chk({ns_lock, s_lock, safety_lock} == '0, "R8 locks cleared by system reset",
            32'({ns_lock, s_lock, safety_lock}), 32'h0);
        rdw(2'd3, rd); chk(rd == 32'h1, "R8 full flag survives system reset", rd, 32'h1);
        @(negedge clk); por_n = 1'b0; sys_rst_n = 1'b0;
        repeat (2) @(negedge clk); por_n = 1'b1; sys_rst_n = 1'b1;
        @(negedge clk);
        rdw(2'd3, rd); chk(rd == 32'h0, "R8 power-on reset clears full flag", rd, 32'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule